// File: doc/BRIEF.md
# Configuration EEPROM Byte-Read Controller

This block fetches single bytes from an attached configuration EEPROM on behalf of a host. The host sees two 32-bit words on a small register bus: a command/status word and a data word. The host starts a read by writing the command word with the busy bit set, a read operation code and a 9-bit byte address. It then polls until busy drops. Afterwards the data word carries the fetched byte, or the command word shows that the device never answered.

The serial pin protocol is not part of this block. Reads leave the block as a request/acknowledge handshake toward a memory agent, which can be a serial engine or a behavioural model. A bounded wait, set by a parameter, guards every request. A separate flag shows whether a device is present, so the host can tell a missing part from a slow one.

Command word layout: bit 31 busy, bits 30:28 operation (000 = read), bit 10 timeout, bit 9 device-loaded, bits 8:0 byte address. Data word layout: bits 7:0 hold the last byte read; bits 31:8 read as zero.

Top module: `eeprom_rd_ctrl`

## Requirements
- R1: After reset, busy, the timeout flag, the address field and the data word all read 0 and `mem_req` is low; the loaded flag follows `dev_present`.
- R2: A write to the command word (`bus_sel`=0) with bit 31 set and bits 30:28 equal to 000, made while idle, sets busy from the next cycle and raises `mem_req` with `mem_addr` equal to bits 8:0 of the written word.
- R3: When `mem_ack` is sampled high during a request, `mem_rdata` is stored into data bits 7:0 (bits 31:8 zero), and busy and `mem_req` fall at that same edge; busy stays high for exactly the number of cycles up to and including the acknowledge.
- R4: Bits 8:0 of the command word read back the address of the most recently accepted read.
- R5: A write to the command word while busy is set has no effect: the address, the pending read and its result are unchanged.
- R6: A command-word write whose bit 31 is clear, or whose bits 30:28 are not 000, starts nothing, and busy and the address field are unchanged.
- R7: If no acknowledge arrives within TMO_CYCLES cycles of the request, busy and `mem_req` fall, bit 10 is set, and the data word keeps its previous value.
- R8: Bit 10 clears when the next read is accepted.
- R9: Bit 9 equals `dev_present` as sampled at the previous clock edge, and reads 0 whenever no device is present.
- R10: Writes to the data word (`bus_sel`=1) do not change it; only an accepted acknowledge does.
- R11: An acknowledge arriving in the last allowed cycle (cycle TMO_CYCLES) completes the read without setting bit 10; one cycle later it is too late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_sel | input | 1 | Word select: 0 command/status, 1 data |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for the selected word |
| dev_present | input | 1 | High when an EEPROM is detected |
| mem_req | output | 1 | Read request to the memory agent |
| mem_addr | output | 9 | Byte address of the request |
| mem_ack | input | 1 | Memory agent returns the byte this cycle |
| mem_rdata | input | 8 | Byte returned with the acknowledge |

## Verification
The bench sets TMO_CYCLES to 16 instead of the default 1024. With that value a missed acknowledge ends in a few dozen cycles, so timeouts can be exercised repeatedly. It also means the acknowledge-in-the-last-cycle case and the one-cycle-late case each need only a short directed memory latency, and the busy duration can be counted exactly against the limit.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  localparam int ADDR_W      = 9;
  localparam int WORD_W      = 32;
  localparam int BYTE_W      = 8;
  localparam int BUSY_BIT    = 31;
  localparam int OP_HI       = 30;
  localparam int OP_LO       = 28;
  localparam int OP_W        = OP_HI - OP_LO + 1;
  localparam int TMO_BIT     = 10;
  localparam int LOADED_BIT  = 9;
  localparam logic [OP_W-1:0] OP_READ = '0;
  localparam logic SEL_CMD   = 1'b0;
  localparam logic SEL_DATA  = 1'b1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rd_state_t;
endpackage

// File: rtl/eeprom_rd_rst_sync.sv
module eeprom_rd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/eeprom_rd_decode.sv
module eeprom_rd_decode
  import eeprom_rd_pkg::*;
(
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              busy,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr
);
  logic cmd_wr;
  logic is_read;
  logic unused_wbits;

  always_comb begin
    cmd_wr     = bus_wr && (bus_sel == SEL_CMD);
    is_read    = bus_wdata[BUSY_BIT] && (bus_wdata[OP_HI:OP_LO] == OP_READ);
    // Writes while busy, non-read codes and clear busy bits start nothing.
    start      = cmd_wr && is_read && !busy;
    start_addr = bus_wdata[ADDR_W-1:0];
  end

  assign unused_wbits = ^bus_wdata[OP_LO-1:ADDR_W];
endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
  import eeprom_rd_pkg::*;
#(
  parameter int TMO_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mem_ack,
  output logic busy,
  output logic done,
  output logic tmo_hit
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  rd_state_t      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done    = 1'b0;
    tmo_hit = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (mem_ack) begin
          // Acknowledge wins over a timeout in the same cycle.
          done    = 1'b1;
          state_d = ST_IDLE;
        end else if (cnt_q == LAST) begin
          tmo_hit = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (state_q == ST_WAIT);
endmodule

// File: rtl/eeprom_rd_status.sv
module eeprom_rd_status
  import eeprom_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              done,
  input  logic              tmo_hit,
  input  logic              busy,
  input  logic              dev_present,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              bus_sel,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BYTE_W-1:0] data_q,
  output logic              tmo_q,
  output logic              loaded_q,
  output logic [WORD_W-1:0] bus_rdata
);
  logic tmo_en, tmo_d;

  always_comb begin
    tmo_en = start || tmo_hit;
    tmo_d  = tmo_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (start) addr_q <= start_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (done) data_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_q <= 1'b0;
    else if (tmo_en) tmo_q <= tmo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loaded_q <= 1'b0;
    else        loaded_q <= dev_present;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel == SEL_DATA) begin
      bus_rdata[BYTE_W-1:0] = data_q;
    end else begin
      bus_rdata[BUSY_BIT]     = busy;
      bus_rdata[OP_HI:OP_LO]  = OP_READ;
      bus_rdata[TMO_BIT]      = tmo_q;
      bus_rdata[LOADED_BIT]   = loaded_q;
      bus_rdata[ADDR_W-1:0]   = addr_q;
    end
  end
endmodule

// File: rtl/eeprom_rd_ctrl.sv
module eeprom_rd_ctrl
  import eeprom_rd_pkg::*;
#(
  parameter int TMO_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              dev_present,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic              rst_n_s;
  logic              start;
  logic [ADDR_W-1:0] start_addr;
  logic              busy;
  logic              done;
  logic              tmo_hit;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;
  logic              tmo_q;
  logic              loaded_q;

  eeprom_rd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  eeprom_rd_decode u_dec (
    .bus_wr     (bus_wr),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .start      (start),
    .start_addr (start_addr)
  );

  eeprom_rd_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start   (start),
    .mem_ack (mem_ack),
    .busy    (busy),
    .done    (done),
    .tmo_hit (tmo_hit)
  );

  eeprom_rd_status u_sts (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start       (start),
    .start_addr  (start_addr),
    .done        (done),
    .tmo_hit     (tmo_hit),
    .busy        (busy),
    .dev_present (dev_present),
    .mem_rdata   (mem_rdata),
    .bus_sel     (bus_sel),
    .addr_q      (addr_q),
    .data_q      (data_q),
    .tmo_q       (tmo_q),
    .loaded_q    (loaded_q),
    .bus_rdata   (bus_rdata)
  );

  assign mem_req  = busy;
  assign mem_addr = addr_q;
endmodule

// File: rtl/eeprom_rd_ctrl_chk.sv
module eeprom_rd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       tmo,
  input logic       mem_req,
  input logic       mem_ack,
  input logic [8:0] mem_addr,
  input logic [7:0] data_q,
  input logic       dev_present,
  input logic       loaded,
  input logic       bus_wr,
  input logic       bus_sel
);
  assert_busy_end_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(mem_ack) || tmo));

  assert_addr_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && !bus_sel) |=> $stable(mem_addr));

  assert_tmo_ends_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> (!busy && !mem_req));

  assert_tmo_clear_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tmo);

  assert_loaded_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_present |=> loaded);

  assert_loaded_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_present |=> !loaded);

  assert_data_on_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(mem_ack && mem_req));
endmodule

bind eeprom_rd_ctrl eeprom_rd_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .busy        (busy),
  .tmo         (tmo_q),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .data_q      (data_q),
  .dev_present (dev_present),
  .loaded      (loaded_q),
  .bus_wr      (bus_wr),
  .bus_sel     (bus_sel)
);

// File: tb/eeprom_rd_ctrl_tb_top.sv
module eeprom_rd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 16;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_sel;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        dev_present;
  logic        mem_req;
  logic [8:0]  mem_addr;
  logic        mem_ack;
  logic [7:0]  mem_rdata;

  int n_checks;
  int n_fails;
  int mem_lat;
  int busy_cnt;
  logic [31:0] rd;

  eeprom_rd_ctrl #(.TMO_CYCLES(TMO)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_sel     (bus_sel),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .dev_present (dev_present),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [7:0] mem_byte(input logic [8:0] a);
    int v;
    v = int'(a) * 7 + 27;
    return v[7:0];
  endfunction

  function automatic logic [31:0] cmd_word(input logic b, input logic [2:0] op,
                                           input logic [8:0] a);
    return {b, op, 19'd0, a};
  endfunction

  // Memory agent: acknowledges mem_lat cycles after the request rises.
  initial begin
    int cnt;
    cnt = 0;
    mem_ack = 1'b0;
    mem_rdata = 8'h00;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        cnt++;
        if (cnt == mem_lat) begin
          mem_ack   = 1'b1;
          mem_rdata = mem_byte(mem_addr);
        end
      end else begin
        cnt = 0;
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic bus_write(input logic sel, input logic [31:0] w);
    bus_sel   = sel;
    bus_wdata = w;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic read_word(input logic sel, output logic [31:0] v);
    bus_sel = sel;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_idle();
    busy_cnt = 0;
    while (bus_rdata[31] === 1'b1 && busy_cnt < 1000) begin
      busy_cnt++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    read_word(1'b0, rd);
    check(rd, 32'h0000_0200, "R1 cmd word after reset");
    read_word(1'b1, rd);
    check(rd, 32'h0, "R1 data word after reset");
    check({31'd0, mem_req}, 32'd0, "R1 mem_req after reset");
  endtask

  task automatic t_read(input logic [8:0] a, input int lat, input string tag);
    mem_lat = lat;
    bus_write(1'b0, cmd_word(1'b1, 3'b000, a));
    read_word(1'b0, rd);
    check({31'd0, rd[31]}, 32'd1, {tag, " R2 busy after start"});
    check({31'd0, mem_req}, 32'd1, {tag, " R2 mem_req"});
    check({23'd0, mem_addr}, {23'd0, a}, {tag, " R2 mem_addr"});
    check({31'd0, rd[10]}, 32'd0, {tag, " R8 timeout cleared on start"});
    wait_idle();
    check(busy_cnt, lat, {tag, " R3 busy cycles"});
    read_word(1'b1, rd);
    check(rd, {24'd0, mem_byte(a)}, {tag, " R3 data byte"});
    read_word(1'b0, rd);
    check({22'd0, rd[9:0]}, {22'd1, a}, {tag, " R4 address readback"});
    check({31'd0, rd[10]}, 32'd0, {tag, " R11 no timeout"});
    check({31'd0, mem_req}, 32'd0, {tag, " R3 mem_req dropped"});
  endtask

  task automatic t_timeout(input logic [8:0] a, input int lat, input logic [7:0] prev);
    mem_lat = lat;
    bus_write(1'b0, cmd_word(1'b1, 3'b000, a));
    wait_idle();
    check(busy_cnt, TMO, "R7 busy cycles until timeout");
    read_word(1'b0, rd);
    check({31'd0, rd[10]}, 32'd1, "R7 timeout flag set");
    check({31'd0, rd[31]}, 32'd0, "R7 busy clear");
    check({31'd0, mem_req}, 32'd0, "R7 mem_req dropped");
    read_word(1'b1, rd);
    check(rd, {24'd0, prev}, "R7 data kept");
  endtask

  task automatic t_write_while_busy();
    mem_lat = 6;
    bus_write(1'b0, cmd_word(1'b1, 3'b000, 9'h0A5));
    bus_write(1'b0, cmd_word(1'b1, 3'b000, 9'h133));
    check({23'd0, mem_addr}, 32'h0A5, "R5 address held while busy");
    wait_idle();
    read_word(1'b1, rd);
    check(rd, {24'd0, mem_byte(9'h0A5)}, "R5 data from first read");
    repeat (5) @(negedge clk);
    check({31'd0, mem_req}, 32'd0, "R5 no second read");
    read_word(1'b0, rd);
    check({23'd0, rd[8:0]}, 32'h0A5, "R5 address field unchanged");
  endtask

  task automatic t_bad_cmd();
    bus_write(1'b0, cmd_word(1'b1, 3'b010, 9'h055));
    read_word(1'b0, rd);
    check({31'd0, rd[31]}, 32'd0, "R6 bad op no busy");
    check({23'd0, rd[8:0]}, 32'h0A5, "R6 bad op address unchanged");
    bus_write(1'b0, cmd_word(1'b0, 3'b000, 9'h066));
    read_word(1'b0, rd);
    check({31'd0, rd[31]}, 32'd0, "R6 busy bit clear no start");
    check({23'd0, rd[8:0]}, 32'h0A5, "R6 clear busy address unchanged");
    check({31'd0, mem_req}, 32'd0, "R6 no request");
  endtask

  task automatic t_data_write();
    read_word(1'b1, rd);
    bus_write(1'b1, 32'hFFFF_FFFF);
    read_word(1'b1, bus_wdata);
    check(bus_wdata, rd, "R10 data word unchanged by host write");
    check({31'd0, mem_req}, 32'd0, "R10 no request from data write");
  endtask

  task automatic t_loaded();
    dev_present = 1'b0;
    @(negedge clk);
    read_word(1'b0, rd);
    check({31'd0, rd[9]}, 32'd0, "R9 loaded low without device");
    dev_present = 1'b1;
    @(negedge clk);
    read_word(1'b0, rd);
    check({31'd0, rd[9]}, 32'd1, "R9 loaded high with device");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    summary_and_end();
  end

  initial begin
    n_checks = 0;
    n_fails = 0;
    mem_lat = 1000;
    bus_wr = 1'b0;
    bus_sel = 1'b0;
    bus_wdata = '0;
    dev_present = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    t_reset();
    t_read(9'h003, 3, "short");
    t_read(9'h1FF, 9, "top address");
    t_read(9'h000, 1, "lat1");
    t_timeout(9'h040, 1000, mem_byte(9'h000));
    t_read(9'h100, 5, "after timeout");
    t_read(9'h07E, TMO, "R11 last cycle ack");
    t_timeout(9'h081, TMO + 1, mem_byte(9'h07E));
    t_write_while_busy();
    t_bad_cmd();
    t_data_write();
    t_loaded();
    repeat (2) @(negedge clk);
    summary_and_end();
  end
endmodule